// File: doc/BRIEF.md
# Direct-Mapped Cache Miss Controller with Selectable Write Policies

This block is one level of a memory hierarchy. It is a direct-mapped cache that sits between an upstream requester and a downstream memory port. The requester issues single-word reads and writes. The controller resolves each one as a hit or a miss and keeps a valid bit, a dirty bit and a tag for every line. When needed, it sequences a victim writeback, a line fill or a single-word write to the level below.

Two parameters choose the policy at build time:
- `WRITE_BACK` selects write-back (1) or write-through (0).
- `WRITE_ALLOC` selects allocate (1) or bypass (0) on a write miss.

A miss that needs a fill always evicts first. A dirty victim's whole block is written down, and every beat is acknowledged, before the new block is requested. After a fill, the controller looks the request up again. The now-resident line then serves it as a hit. So a read miss returns its word from the installed line, and an allocating write miss then follows the configured write policy.

Addresses are word addresses laid out as `{tag, index, offset}`, with the offset in the low `log2(LINE_WORDS)` bits and the index just above it.

Top module: `cache_miss_ctrl`

## Requirements
- R1: After reset `up_ready` and `dn_req` are low and every line is invalid. The first access to any index misses and issues only a block read, with no writeback.
- R2: A read hit returns the stored word on `up_rdata` with a one-cycle `up_ready` pulse, and causes no downstream transfer.
- R3: A read miss issues one block read (`dn_we`=0, `dn_blk`=1) at the block-aligned address of the requested word. The requested word is returned with `up_ready` after the fill completes.
- R4: In write-back mode a write hit updates the word in the line and marks the line dirty, with no downstream transfer. The new word is returned by later reads and is written down when the line is evicted.
- R5: In write-through mode a write hit updates the word and issues exactly one single-word downstream write (`dn_blk`=0) of the same address and data. A line is never dirty in this mode, so evicting it causes no writeback.
- R6: When the indexed line is valid and dirty on a miss that needs a fill, the controller writes the victim as a full block to its own block-aligned address. It completes all beats of that write before the fill request is issued.
- R7: A valid but clean victim is dropped with no downstream write; the fill follows directly.
- R8: With write-allocate, a write miss first fills the containing block and then applies the configured write policy to the installed line.
- R9: With no-write-allocate, a write miss issues only a single-word downstream write. The cache contents, including the line at that index, stay unchanged.
- R10: While `dn_req` is held without `dn_ack`, `dn_addr`, `dn_we` and `dn_blk` stay stable. A block transfer takes exactly `LINE_WORDS` acknowledged beats, at addresses `dn_addr`+0 upward. A word transfer takes one beat.
- R11: `up_ready` is a single-cycle pulse. No downstream request is active in the cycle it is high, and one request is handled at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Upstream request, held until `up_ready` |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Upstream word address |
| up_wdata | input | DATA_W | Upstream write word |
| up_rdata | output | DATA_W | Read word, valid with `up_ready` |
| up_ready | output | 1 | One-cycle completion pulse |
| dn_req | output | 1 | Downstream request, held until the last acknowledge |
| dn_we | output | 1 | 1 = write, 0 = read |
| dn_blk | output | 1 | 1 = whole block, 0 = single word |
| dn_addr | output | ADDR_W | Word address; block-aligned for block transfers |
| dn_wdata | output | DATA_W | Write word for the current beat |
| dn_rdata | input | DATA_W | Read word, valid with `dn_ack` |
| dn_ack | input | 1 | Single-cycle beat acknowledge |

## Verification
The assertions assume three things about the inputs:
- The requester holds `up_req`, `up_we`, `up_addr` and `up_wdata` steady from request until `up_ready`, and drops `up_req` in that cycle.
- The memory raises `dn_ack` only while `dn_req` is high.
- Read data is presented together with `dn_ack`.

The bench's requester task changes request fields only before asserting `up_req` and releases it on the falling edge where it sees `up_ready`. Its memory model acknowledges every other cycle, and only in response to a pending request. The model also counts any command or address change seen during a held request.

// File: rtl/cc_pkg.sv
// Shared types for the cache miss controller.
package cc_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_WDOWN = 2'd3
    } cc_state_e;

endpackage

// File: rtl/cc_tag_store.sv
// Per-line tag, valid and dirty state.
// Assumes: one lookup index per cycle; the fill and dirty updates apply to
// the looked-up index. A fill wins over a dirty mark in the same cycle.
module cc_tag_store #(
    parameter int TAG_W     = 5,
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic             lk_dirty,
    output logic [TAG_W-1:0] lk_tag,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_en
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Flag bits of one line: cleared by reset, set by fill or write hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (fill_en && lk_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                dirty_q[g] <= 1'b0;
            end else if (dirty_en && lk_idx == IDX_W'(g)) begin
                dirty_q[g] <= 1'b1;
            end
        end

        // Tag of one line: loaded on fill.
        always_ff @(posedge clk) begin
            if (fill_en && lk_idx == IDX_W'(g)) begin
                tag_q[g] <= fill_tag;
            end
        end
    end

    // Lookup of the indexed line.
    always_comb begin
        lk_valid = valid_q[lk_idx];
        lk_dirty = dirty_q[lk_idx];
        lk_tag   = tag_q[lk_idx];
    end
endmodule

// File: rtl/cc_data_store.sv
// Line data storage: one write port and one combinational read port, each
// addressed by line and word within the line. No reset; the valid bits in
// the tag store guard every read.
module cc_data_store #(
    parameter int DATA_W     = 32,
    parameter int NUM_LINES  = 8,
    parameter int LINE_WORDS = 4,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int DEPTH     = NUM_LINES * LINE_WORDS
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_line,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_line,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Word write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_line, wr_word}] <= wr_data;
        end
    end

    // Word read.
    always_comb rd_data = mem_q[{rd_line, rd_word}];
endmodule

// File: rtl/cache_miss_ctrl.sv
// Direct-mapped cache controller with build-time write policy.
// WRITE_BACK=1 gives write-back, 0 write-through. WRITE_ALLOC=1 allocates on
// a write miss, 0 bypasses. A miss needing a fill evicts a dirty victim
// first, then fills, then returns to idle so that the held request
// completes as a hit.
// Assumes: upstream request fields stay stable until up_ready; dn_ack only
// while dn_req; LINE_WORDS and NUM_LINES are powers of two, at least 2.
module cache_miss_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int NUM_LINES   = 8,
    parameter int WRITE_BACK  = 1,
    parameter int WRITE_ALLOC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_we,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_ready,
    output logic              dn_req,
    output logic              dn_we,
    output logic              dn_blk,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_ack
);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam bit WB_MODE = (WRITE_BACK != 0);
    localparam bit WA_MODE = (WRITE_ALLOC != 0);

    cc_state_e         state_q;
    logic [OFF_W-1:0]  beat_q;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic              lk_valid, lk_dirty;
    logic [TAG_W-1:0]  lk_tag;
    logic              hit, accept, last_beat;
    logic              wr_en, fill_en, dirty_en;
    logic [OFF_W-1:0]  wr_word, rd_word;
    logic [DATA_W-1:0] wr_data, rd_data;

    // Address split and lookup qualifiers.
    always_comb begin
        req_tag   = up_addr[ADDR_W-1 -: TAG_W];
        req_idx   = up_addr[OFF_W +: IDX_W];
        req_off   = up_addr[OFF_W-1:0];
        hit       = lk_valid && (lk_tag == req_tag);
        accept    = (state_q == ST_IDLE) && up_req && !up_ready;
        last_beat = (beat_q == OFF_W'(LINE_WORDS - 1));
    end

    // Storage update strobes and data-port steering.
    always_comb begin
        fill_en  = (state_q == ST_FILL) && dn_ack && last_beat;
        dirty_en = accept && hit && up_we && WB_MODE;
        wr_en    = (accept && hit && up_we) || ((state_q == ST_FILL) && dn_ack);
        wr_word  = (state_q == ST_FILL) ? beat_q : req_off;
        wr_data  = (state_q == ST_FILL) ? dn_rdata : up_wdata;
        rd_word  = (state_q == ST_EVICT) ? beat_q : req_off;
    end

    cc_tag_store #(
        .TAG_W     (TAG_W),
        .NUM_LINES (NUM_LINES)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (req_idx),
        .lk_valid (lk_valid),
        .lk_dirty (lk_dirty),
        .lk_tag   (lk_tag),
        .fill_en  (fill_en),
        .fill_tag (req_tag),
        .dirty_en (dirty_en)
    );

    cc_data_store #(
        .DATA_W     (DATA_W),
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS)
    ) u_data (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_line (req_idx),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .rd_line (req_idx),
        .rd_word (rd_word),
        .rd_data (rd_data)
    );

    // Sequencer: hit service, evict-then-fill, word write-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            up_ready <= 1'b0;
            up_rdata <= '0;
        end else begin
            up_ready <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            if (!up_we) begin
                                up_rdata <= rd_data;
                                up_ready <= 1'b1;
                            end else if (WB_MODE) begin
                                up_ready <= 1'b1;
                            end else begin
                                state_q <= ST_WDOWN;
                            end
                        end else if (up_we && !WA_MODE) begin
                            state_q <= ST_WDOWN;
                        end else if (lk_valid && lk_dirty) begin
                            state_q <= ST_EVICT;
                            beat_q  <= '0;
                        end else begin
                            state_q <= ST_FILL;
                            beat_q  <= '0;
                        end
                    end
                end
                ST_EVICT: begin
                    if (dn_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            state_q <= ST_FILL;
                            beat_q  <= '0;
                        end
                    end
                end
                ST_FILL: begin
                    if (dn_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                            beat_q  <= '0;
                        end
                    end
                end
                ST_WDOWN: begin
                    if (dn_ack) begin
                        up_ready <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Downstream command decode from state.
    always_comb begin
        dn_req   = (state_q != ST_IDLE);
        dn_we    = (state_q == ST_EVICT) || (state_q == ST_WDOWN);
        dn_blk   = (state_q == ST_EVICT) || (state_q == ST_FILL);
        dn_addr  = '0;
        dn_wdata = '0;
        case (state_q)
            ST_EVICT: begin
                dn_addr  = {lk_tag, req_idx, {OFF_W{1'b0}}};
                dn_wdata = rd_data;
            end
            ST_FILL:  dn_addr = {req_tag, req_idx, {OFF_W{1'b0}}};
            ST_WDOWN: begin
                dn_addr  = up_addr;
                dn_wdata = up_wdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cc_ctrl_checker.sv
// Protocol and ordering checks for cache_miss_ctrl, attached by bind.
// Assumes dn_ack is only raised while dn_req is high.
module cc_ctrl_checker #(
    parameter int ADDR_W     = 10,
    parameter int LINE_WORDS = 4,
    parameter int WRITE_BACK = 1,
    localparam int OFF_W     = $clog2(LINE_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_ready,
    input logic              dn_req,
    input logic              dn_we,
    input logic              dn_blk,
    input logic              dn_ack,
    input logic [ADDR_W-1:0] dn_addr
);
    logic [OFF_W-1:0] blk_beats_q;
    logic             evict_done;

    // Count acknowledged beats of block transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_beats_q <= '0;
        end else if (dn_ack && dn_blk) begin
            blk_beats_q <= blk_beats_q + 1'b1;
        end
    end

    // Final beat of a block writeback.
    always_comb evict_done = dn_ack && dn_we && dn_blk &&
                             (blk_beats_q == OFF_W'(LINE_WORDS - 1));

    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |=> !up_ready);

    a_r11_quiet_at_ready: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> !dn_req);

    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_blk)));

    a_r10_blk_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_blk) |-> (dn_addr[OFF_W-1:0] == '0));

    a_r6_fill_after_evict: assert property (@(posedge clk) disable iff (!rst_n)
        evict_done |=> (dn_req && !dn_we && dn_blk));

    a_r5_no_blk_write_wt: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_we && dn_blk) |-> (WRITE_BACK != 0));
endmodule

bind cache_miss_ctrl cc_ctrl_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_WORDS (LINE_WORDS),
    .WRITE_BACK (WRITE_BACK)
) u_cc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_ready (up_ready),
    .dn_req   (dn_req),
    .dn_we    (dn_we),
    .dn_blk   (dn_blk),
    .dn_ack   (dn_ack),
    .dn_addr  (dn_addr)
);

// File: tb/cache_miss_ctrl_bench.sv
`timescale 1ns/1ps

// Downstream memory model: acknowledges every other cycle, logs each
// completed transfer (1 word write, 2 block write, 3 block read), counts
// protocol errors.
module cc_mem_model #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dn_req,
    input  logic              dn_we,
    input  logic              dn_blk,
    input  logic [ADDR_W-1:0] dn_addr,
    input  logic [DATA_W-1:0] dn_wdata,
    output logic [DATA_W-1:0] dn_rdata,
    output logic              dn_ack
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [1:0]        log_k [64];
    int                n_done;
    int                n_err;
    logic [OFF_W-1:0]  beat;
    logic              pend;
    logic [ADDR_W-1:0] p_addr;
    logic              p_we, p_blk;
    logic [ADDR_W-1:0] cur;

    always_comb cur = dn_blk ? (dn_addr + ADDR_W'(beat)) : dn_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_ack   <= 1'b0;
            dn_rdata <= '0;
            beat     <= '0;
            n_done   <= 0;
            n_err    <= 0;
            pend     <= 1'b0;
            p_addr   <= '0;
            p_we     <= 1'b0;
            p_blk    <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(32'hC0DE0000) | DATA_W'(i);
        end else begin
            dn_ack <= 1'b0;
            pend   <= dn_req && !dn_ack;
            p_addr <= dn_addr;
            p_we   <= dn_we;
            p_blk  <= dn_blk;
            if (pend && (dn_addr != p_addr || dn_we != p_we || dn_blk != p_blk)) n_err <= n_err + 1;
            if (dn_req && !dn_ack) begin
                dn_ack   <= 1'b1;
                dn_rdata <= mem[cur];
            end
            if (dn_ack) begin
                if (!dn_req) n_err <= n_err + 1;
                if (dn_blk && dn_addr[OFF_W-1:0] != '0) n_err <= n_err + 1;
                if (dn_we) mem[cur] <= dn_wdata;
                if (dn_blk) begin
                    if (beat == OFF_W'(LINE_WORDS - 1)) begin
                        beat <= '0;
                        log_k[n_done % 64] <= dn_we ? 2'd2 : 2'd3;
                        n_done <= n_done + 1;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end else begin
                    log_k[n_done % 64] <= 2'd1;
                    n_done <= n_done + 1;
                end
            end
        end
    end
endmodule

module cache_miss_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fails  = 0;

    always #2 clk = ~clk;

    // Instance A: write-back, write-allocate. Instance B: write-through, no-allocate.
    logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
    logic [9:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_ready, b_ready;
    logic        a_dn_req, a_dn_we, a_dn_blk, a_dn_ack;
    logic        b_dn_req, b_dn_we, b_dn_blk, b_dn_ack;
    logic [9:0]  a_dn_addr, b_dn_addr;
    logic [31:0] a_dn_wdata, b_dn_wdata, a_dn_rdata, b_dn_rdata;

    cache_miss_ctrl u_cache_miss_ctrl (
        .clk(clk), .rst_n(rst_n), .up_req(a_req), .up_we(a_we), .up_addr(a_addr),
        .up_wdata(a_wdata), .up_rdata(a_rdata), .up_ready(a_ready),
        .dn_req(a_dn_req), .dn_we(a_dn_we), .dn_blk(a_dn_blk), .dn_addr(a_dn_addr),
        .dn_wdata(a_dn_wdata), .dn_rdata(a_dn_rdata), .dn_ack(a_dn_ack));

    cache_miss_ctrl #(.WRITE_BACK(0), .WRITE_ALLOC(0)) u_cache_miss_ctrl_wt (
        .clk(clk), .rst_n(rst_n), .up_req(b_req), .up_we(b_we), .up_addr(b_addr),
        .up_wdata(b_wdata), .up_rdata(b_rdata), .up_ready(b_ready),
        .dn_req(b_dn_req), .dn_we(b_dn_we), .dn_blk(b_dn_blk), .dn_addr(b_dn_addr),
        .dn_wdata(b_dn_wdata), .dn_rdata(b_dn_rdata), .dn_ack(b_dn_ack));

    cc_mem_model u_mem_a (
        .clk(clk), .rst_n(rst_n), .dn_req(a_dn_req), .dn_we(a_dn_we), .dn_blk(a_dn_blk),
        .dn_addr(a_dn_addr), .dn_wdata(a_dn_wdata), .dn_rdata(a_dn_rdata), .dn_ack(a_dn_ack));

    cc_mem_model u_mem_b (
        .clk(clk), .rst_n(rst_n), .dn_req(b_dn_req), .dn_we(b_dn_we), .dn_blk(b_dn_blk),
        .dn_addr(b_dn_addr), .dn_wdata(b_dn_wdata), .dn_rdata(b_dn_rdata), .dn_ack(b_dn_ack));

    // Vector: {we, addr[9:0], wdata[31:0], exp_rdata[31:0], exp_hist[5:0], exp_n[1:0]}
    // hist packs up to three transfer codes, first in the top bits:
    // 6'h30 = block read; 6'h2C = block write then block read; 6'h10 = word write.
    localparam int NV = 9;
    localparam logic [82:0] VEC [NV] = '{
        {1'b0, 10'h004, 32'h0,        32'hC0DE0004, 6'h30, 2'd1},
        {1'b0, 10'h007, 32'h0,        32'hC0DE0007, 6'h00, 2'd0},
        {1'b1, 10'h005, 32'h11111111, 32'h0,        6'h00, 2'd0},
        {1'b0, 10'h005, 32'h0,        32'h11111111, 6'h00, 2'd0},
        {1'b0, 10'h024, 32'h0,        32'hC0DE0024, 6'h2C, 2'd2},
        {1'b0, 10'h044, 32'h0,        32'hC0DE0044, 6'h30, 2'd1},
        {1'b1, 10'h0A8, 32'h22222222, 32'h0,        6'h30, 2'd1},
        {1'b0, 10'h0A8, 32'h0,        32'h22222222, 6'h00, 2'd0},
        {1'b0, 10'h0C8, 32'h0,        32'hC0DE00C8, 6'h2C, 2'd2}
    };

    function automatic string vec_req(input int i);
        case (i)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R4";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One upstream operation on instance A (sel=0) or B (sel=1).
    task automatic do_op(input bit sel, input bit we, input logic [9:0] addr,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output int nx, output logic [5:0] hist);
        int  start;
        bit  got;
        start = sel ? u_mem_b.n_done : u_mem_a.n_done;
        @(negedge clk);
        if (sel) begin b_req = 1; b_we = we; b_addr = addr; b_wdata = wd; end
        else     begin a_req = 1; a_we = we; a_addr = addr; a_wdata = wd; end
        got = 0;
        rd  = '0;
        for (int c = 0; c < 300 && !got; c++) begin
            @(negedge clk);
            if (sel ? b_ready : a_ready) begin
                got = 1;
                rd  = sel ? b_rdata : a_rdata;
                check32("R11 no downstream request at ready", 32'(sel ? b_dn_req : a_dn_req), 32'd0);
            end
        end
        if (sel) b_req = 0; else a_req = 0;
        check32("R11 request completes", 32'(got), 32'd1);
        @(negedge clk);
        check32("R11 ready is one cycle", 32'(sel ? b_ready : a_ready), 32'd0);
        nx   = (sel ? u_mem_b.n_done : u_mem_a.n_done) - start;
        hist = '0;
        for (int k = 0; k < nx && k < 3; k++) begin
            hist[5 - 2*k -: 2] = sel ? u_mem_b.log_k[(start + k) % 64]
                                     : u_mem_a.log_k[(start + k) % 64];
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [5:0]  hist;
        int          nx;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports.
        check32("R1 a up_ready after reset", 32'(a_ready), 32'd0);
        check32("R1 a dn_req after reset",   32'(a_dn_req), 32'd0);
        check32("R1 b dn_req after reset",   32'(b_dn_req), 32'd0);

        // Table walk on the write-back, write-allocate instance.
        for (int i = 0; i < NV; i++) begin
            do_op(1'b0, VEC[i][82], VEC[i][81:72], VEC[i][71:40], rd, nx, hist);
            if (!VEC[i][82]) check32({vec_req(i), " read data"}, rd, VEC[i][39:8]);
            check32({vec_req(i), " transfer count"}, 32'(nx), 32'(VEC[i][1:0]));
            check32({vec_req(i), " transfer order"}, 32'(hist), 32'(VEC[i][7:2]));
        end
        check32("R4 dirty word written back on eviction", u_mem_a.mem[10'h005], 32'h11111111);
        check32("R6 victim block written at its own address", u_mem_a.mem[10'h007], 32'hC0DE0007);
        check32("R8 allocated write reached memory on eviction", u_mem_a.mem[10'h0A8], 32'h22222222);
        check32("R10 protocol errors instance a", 32'(u_mem_a.n_err), 32'd0);

        // Directed tests on the write-through, no-allocate instance.
        do_op(1'b1, 1'b0, 10'h010, 32'h0, rd, nx, hist);
        check32("R3 wt read miss data", rd, 32'hC0DE0010);
        check32("R3 wt read miss transfers", 32'(hist), 32'h30);

        do_op(1'b1, 1'b1, 10'h011, 32'h33333333, rd, nx, hist);
        check32("R5 write hit one word write", 32'(hist), 32'h10);
        check32("R5 write hit count", 32'(nx), 32'd1);
        check32("R5 word reached memory", u_mem_b.mem[10'h011], 32'h33333333);

        do_op(1'b1, 1'b0, 10'h011, 32'h0, rd, nx, hist);
        check32("R5 updated word read back", rd, 32'h33333333);
        check32("R2 hit has no transfer", 32'(nx), 32'd0);

        do_op(1'b1, 1'b0, 10'h050, 32'h0, rd, nx, hist);
        check32("R5 eviction without writeback", 32'(hist), 32'h30);
        check32("R5 eviction read data", rd, 32'hC0DE0050);

        do_op(1'b1, 1'b1, 10'h0F0, 32'h44444444, rd, nx, hist);
        check32("R9 write miss only word write", 32'(hist), 32'h10);
        check32("R9 write miss count", 32'(nx), 32'd1);
        check32("R9 word reached memory", u_mem_b.mem[10'h0F0], 32'h44444444);

        do_op(1'b1, 1'b0, 10'h050, 32'h0, rd, nx, hist);
        check32("R9 resident line unchanged", rd, 32'hC0DE0050);
        check32("R9 resident line still hits", 32'(nx), 32'd0);

        do_op(1'b1, 1'b0, 10'h0F0, 32'h0, rd, nx, hist);
        check32("R9 bypassed word misses", 32'(hist), 32'h30);
        check32("R9 bypassed word data", rd, 32'h44444444);
        check32("R10 protocol errors instance b", 32'(u_mem_b.n_err), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule